// File: doc/BRIEF.md
# Chained SPI Expander Segment Front End

This block is the serial front end of one I/O expander that sits in a chain of identical parts sharing one chip select and one SPI clock. Each device's serial output feeds the next device's serial input. The block takes the SPI pins into its own clock domain and turns them into three things. First, the 16-bit status word it drives out at the start of every frame. Second, a copy of its serial input delayed by exactly one 16-bit segment. Third, a single register command that it decodes when chip select goes high.

Input segments are sorted by the two most significant bits of each 16-bit word. The first input segment of a frame arrives during the device's own status slot and is dropped. In chained mode, the next stage skips any status words forwarded from devices nearer the controller and waits for a header, which carries the chain length. Every segment after that is payload. The controller sends payload pairs for the farthest device first, so the final two complete payload segments of the frame are this device's address and data. In single mode, no header is expected and the payload is exactly one address and one data word.

Top module: `daisy_seg_decoder`

## Requirements
- R1: The serial input is taken on rising SCLK edges and the serial output changes only after falling SCLK edges, so the output holds steady across each rising edge.
- R2: Starting with the chip-select fall, the first 16 output bits, MSB first, are 1, 1, the six fault inputs (bit 5 first) captured at chip-select fall, then eight zeros. The output is 0 while chip select is high.
- R3: From bit 16 of a frame onward, output bit k equals input bit k-16.
- R4: In chained mode, input segments with ID bits[15:14]=2'b11 that follow the dropped first segment are skipped. The first segment with ID 2'b01 is the header, and its bits[12:0] appear on chain_len, with bit 13 ignored. chain_len holds its value between headers.
- R5: On a clean frame end, the second-to-last payload segment is the address and the last is the data. Address bit 15 set gives a one-cycle rd_req, and clear gives a one-cycle wr_stb. cmd_addr takes address bits[14:0] and cmd_data takes the data segment. The strobe appears on the third clock edge after chip select rises.
- R6: If chip select rises after a bit count that is not a multiple of 16, frame_err pulses for one cycle and no command is issued.
- R7: In chained mode, a frame that has no header, fewer than two payload segments, an odd payload count, or more than twice chain_len payload segments pulses seq_err and issues no command.
- R8: In single mode, the segment after the dropped first segment is the address even if its ID is 2'b01, and any payload count other than two pulses seq_err.
- R9: After reset, all strobes, flags, cmd_addr, cmd_data, chain_len and the serial output are 0.
- R10: At most one of wr_stb, rd_req, frame_err and seq_err is high in any cycle, and none stays high for two cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, several times faster than SCLK |
| rst_n | input | 1 | Asynchronous active-low reset |
| daisy_en | input | 1 | 1 = chained mode with header, 0 = single mode (captured at frame start) |
| fault_in | input | 6 | Fault bits placed in the status word |
| spi_sclk | input | 1 | SPI clock pin |
| spi_cs_n | input | 1 | Active-low chip select pin |
| spi_mosi | input | 1 | Serial data from the controller or the previous device |
| spi_miso | output | 1 | Serial data toward the controller or the next device |
| wr_stb | output | 1 | One-cycle register write strobe |
| rd_req | output | 1 | One-cycle register read request |
| cmd_addr | output | 15 | Register address of the last command |
| cmd_data | output | 16 | Data word of the last command |
| chain_len | output | 13 | Device count from the most recent header |
| frame_err | output | 1 | One-cycle pulse: frame ended off a segment boundary |
| seq_err | output | 1 | One-cycle pulse: segment sequence unusable |

## Verification
The final rising SCLK edge, which completes the data segment, and the chip-select rise can be seen in the same sampled clock cycle. If the end-of-frame decision read the counters in that cycle, it would see a segment one bit short. The bench provokes this by raising SCLK and chip select on the same clock for the last bit of two frames, one in each mode. It expects the same clean read or write strobe, address and data that a frame with a gap between the two edges would give, and no frame_err.

// File: rtl/daisy_seg_pkg.sv
package daisy_seg_pkg;

  localparam logic [1:0] ID_HEADER = 2'b01;
  localparam logic [1:0] ID_STATUS = 2'b11;

  typedef enum logic [1:0] {
    PH_SLOT    = 2'd0,
    PH_PREHDR  = 2'd1,
    PH_PAYLOAD = 2'd2
  } phase_e;

endpackage

// File: rtl/dsd_pin_sampler.sv
module dsd_pin_sampler (
  input  logic clk,
  input  logic rst_n,
  input  logic sclk_pin,
  input  logic cs_n_pin,
  input  logic sdi_pin,
  output logic sdi_s,
  output logic sclk_rise,
  output logic sclk_fall,
  output logic frame_start,
  output logic frame_end
);

  logic sclk_s, cs_s, sdi_q;
  logic sclk_prev, cs_prev;
  logic active;

  // Pins are registered once, then compared with the previous sample.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_s    <= 1'b0;
      cs_s      <= 1'b1;
      sdi_q     <= 1'b0;
      sclk_prev <= 1'b0;
      cs_prev   <= 1'b1;
    end else begin
      sclk_s    <= sclk_pin;
      cs_s      <= cs_n_pin;
      sdi_q     <= sdi_pin;
      sclk_prev <= sclk_s;
      cs_prev   <= cs_s;
    end
  end

  // A clock edge seen together with the chip-select rise still counts.
  assign active      = ~cs_prev;
  assign sdi_s       = sdi_q;
  assign sclk_rise   = active & sclk_s & ~sclk_prev;
  assign sclk_fall   = active & ~sclk_s & sclk_prev;
  assign frame_start = ~cs_s & cs_prev;
  assign frame_end   = cs_s & ~cs_prev;

endmodule

// File: rtl/dsd_shift_path.sv
module dsd_shift_path #(
  parameter int SEG_W   = 16,
  parameter int FAULT_W = 6
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               frame_start,
  input  logic               frame_end,
  input  logic               sclk_rise,
  input  logic               sclk_fall,
  input  logic               sdi_s,
  input  logic [FAULT_W-1:0] fault,
  output logic               seg_done,
  output logic [SEG_W-1:0]   seg_word,
  output logic               aligned,
  output logic               sdo
);

  import daisy_seg_pkg::*;

  localparam int CNT_W = $clog2(SEG_W);
  localparam int PAD_W = SEG_W - 2 - FAULT_W;
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(SEG_W - 1);

  logic [SEG_W-1:0] shreg_q, shreg_n;
  logic [SEG_W-1:0] stat_q, stat_n;
  logic [CNT_W-1:0] cnt_q, cnt_n;
  logic             first_q, first_n;
  logic             sdo_q, sdo_n;
  logic             upd_en;
  logic [SEG_W-1:0] status_word;
  logic [CNT_W-1:0] stat_idx;

  assign status_word = {ID_STATUS, fault, {PAD_W{1'b0}}};
  assign stat_idx    = LAST_BIT - cnt_q;
  assign upd_en      = frame_start | frame_end | sclk_rise | sclk_fall;

  always_comb begin
    shreg_n = shreg_q;
    stat_n  = stat_q;
    cnt_n   = cnt_q;
    first_n = first_q;
    sdo_n   = sdo_q;
    if (frame_start) begin
      shreg_n = '0;
      stat_n  = status_word;
      cnt_n   = '0;
      first_n = 1'b1;
      sdo_n   = status_word[SEG_W-1];
    end else begin
      if (sclk_rise) begin
        shreg_n = {shreg_q[SEG_W-2:0], sdi_s};
        if (cnt_q == LAST_BIT) begin
          cnt_n   = '0;
          first_n = 1'b0;
        end else begin
          cnt_n = cnt_q + 1'b1;
        end
      end
      if (frame_end) begin
        sdo_n = 1'b0;
      end else if (sclk_fall) begin
        // Status word during the first segment, then the one-segment delay line.
        sdo_n = first_q ? stat_q[stat_idx] : shreg_q[SEG_W-1];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg_q <= '0;
      stat_q  <= '0;
      cnt_q   <= '0;
      first_q <= 1'b1;
      sdo_q   <= 1'b0;
    end else if (upd_en) begin
      shreg_q <= shreg_n;
      stat_q  <= stat_n;
      cnt_q   <= cnt_n;
      first_q <= first_n;
      sdo_q   <= sdo_n;
    end
  end

  assign seg_done = sclk_rise & (cnt_q == LAST_BIT);
  assign seg_word = {shreg_q[SEG_W-2:0], sdi_s};
  assign aligned  = (cnt_q == '0);
  assign sdo      = sdo_q;

endmodule

// File: rtl/dsd_seg_track.sv
module dsd_seg_track #(
  parameter int SEG_W  = 16,
  parameter int LEN_W  = 13,
  parameter int PCNT_W = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_start,
  input  logic              daisy_en,
  input  logic              seg_done,
  input  logic [SEG_W-1:0]  seg_word,
  output logic              mode,
  output logic              hdr_ok,
  output logic [PCNT_W-1:0] pay_cnt,
  output logic [LEN_W-1:0]  chain_len,
  output logic [SEG_W-1:0]  addr_word,
  output logic [SEG_W-1:0]  data_word
);

  import daisy_seg_pkg::*;

  phase_e            phase_q, phase_n;
  logic              mode_q, mode_n;
  logic              hdr_q, hdr_n;
  logic [PCNT_W-1:0] pay_q, pay_n;
  logic [LEN_W-1:0]  len_q, len_n;
  logic [SEG_W-1:0]  addr_q, addr_n;
  logic [SEG_W-1:0]  data_q, data_n;
  logic              take;
  logic              upd_en;
  logic [1:0]        seg_id;

  assign seg_id = seg_word[SEG_W-1:SEG_W-2];
  assign upd_en = frame_start | seg_done;

  always_comb begin
    phase_n = phase_q;
    mode_n  = mode_q;
    hdr_n   = hdr_q;
    pay_n   = pay_q;
    len_n   = len_q;
    addr_n  = addr_q;
    data_n  = data_q;
    take    = 1'b0;
    if (frame_start) begin
      phase_n = PH_SLOT;
      mode_n  = daisy_en;
      hdr_n   = 1'b0;
      pay_n   = '0;
    end else if (seg_done) begin
      case (phase_q)
        PH_SLOT: phase_n = mode_q ? PH_PREHDR : PH_PAYLOAD;
        PH_PREHDR: begin
          if (seg_id == ID_HEADER) begin
            hdr_n   = 1'b1;
            len_n   = seg_word[LEN_W-1:0];
            phase_n = PH_PAYLOAD;
          end else if (seg_id != ID_STATUS) begin
            phase_n = PH_PAYLOAD;
            take    = 1'b1;
          end
        end
        default: take = 1'b1;
      endcase
      if (take) begin
        if (pay_q != '1) pay_n = pay_q + 1'b1;
        addr_n = data_q;
        data_n = seg_word;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_SLOT;
      mode_q  <= 1'b0;
      hdr_q   <= 1'b0;
      pay_q   <= '0;
      len_q   <= '0;
      addr_q  <= '0;
      data_q  <= '0;
    end else if (upd_en) begin
      phase_q <= phase_n;
      mode_q  <= mode_n;
      hdr_q   <= hdr_n;
      pay_q   <= pay_n;
      len_q   <= len_n;
      addr_q  <= addr_n;
      data_q  <= data_n;
    end
  end

  assign mode      = mode_q;
  assign hdr_ok    = hdr_q;
  assign pay_cnt   = pay_q;
  assign chain_len = len_q;
  assign addr_word = addr_q;
  assign data_word = data_q;

endmodule

// File: rtl/dsd_cmd_issue.sv
module dsd_cmd_issue #(
  parameter int SEG_W  = 16,
  parameter int LEN_W  = 13,
  parameter int PCNT_W = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_end,
  input  logic              aligned,
  input  logic              mode,
  input  logic              hdr_ok,
  input  logic [PCNT_W-1:0] pay_cnt,
  input  logic [LEN_W-1:0]  chain_len,
  input  logic [SEG_W-1:0]  addr_word,
  input  logic [SEG_W-1:0]  data_word,
  output logic              wr_stb,
  output logic              rd_req,
  output logic              frame_err,
  output logic              seq_err,
  output logic [SEG_W-2:0]  cmd_addr,
  output logic [SEG_W-1:0]  cmd_data
);

  logic              end_q;
  logic              wr_q, wr_n, rd_q, rd_n, fe_q, fe_n, se_q, se_n;
  logic [SEG_W-2:0]  addr_q, addr_n;
  logic [SEG_W-1:0]  data_q, data_n;
  logic [PCNT_W-1:0] pay_limit;
  logic              daisy_ok, single_ok, frame_ok;

  assign pay_limit = PCNT_W'({chain_len, 1'b0});
  assign daisy_ok  = hdr_ok && (pay_cnt >= PCNT_W'(2)) && !pay_cnt[0] &&
                     (pay_cnt <= pay_limit);
  assign single_ok = (pay_cnt == PCNT_W'(2));
  assign frame_ok  = mode ? daisy_ok : single_ok;

  // Decision waits one cycle so a final clock edge seen with the
  // chip-select rise has already been shifted in.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) end_q <= 1'b0;
    else        end_q <= frame_end;
  end

  always_comb begin
    wr_n   = 1'b0;
    rd_n   = 1'b0;
    fe_n   = 1'b0;
    se_n   = 1'b0;
    addr_n = addr_q;
    data_n = data_q;
    if (end_q) begin
      if (!aligned) begin
        fe_n = 1'b1;
      end else if (frame_ok) begin
        rd_n   = addr_word[SEG_W-1];
        wr_n   = ~addr_word[SEG_W-1];
        addr_n = addr_word[SEG_W-2:0];
        data_n = data_word;
      end else begin
        se_n = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q   <= 1'b0;
      rd_q   <= 1'b0;
      fe_q   <= 1'b0;
      se_q   <= 1'b0;
      addr_q <= '0;
      data_q <= '0;
    end else begin
      wr_q   <= wr_n;
      rd_q   <= rd_n;
      fe_q   <= fe_n;
      se_q   <= se_n;
      addr_q <= addr_n;
      data_q <= data_n;
    end
  end

  assign wr_stb    = wr_q;
  assign rd_req    = rd_q;
  assign frame_err = fe_q;
  assign seq_err   = se_q;
  assign cmd_addr  = addr_q;
  assign cmd_data  = data_q;

endmodule

// File: rtl/daisy_seg_decoder.sv
module daisy_seg_decoder #(
  parameter int SEG_W   = 16,
  parameter int FAULT_W = 6,
  parameter int LEN_W   = 13
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               daisy_en,
  input  logic [FAULT_W-1:0] fault_in,
  input  logic               spi_sclk,
  input  logic               spi_cs_n,
  input  logic               spi_mosi,
  output logic               spi_miso,
  output logic               wr_stb,
  output logic               rd_req,
  output logic [SEG_W-2:0]   cmd_addr,
  output logic [SEG_W-1:0]   cmd_data,
  output logic [LEN_W-1:0]   chain_len,
  output logic               frame_err,
  output logic               seq_err
);

  localparam int PCNT_W = LEN_W + 2;

  logic rst_meta, rst_sync_n;

  // Reset asserts at once and releases on a clock edge.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta   <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta   <= 1'b1;
      rst_sync_n <= rst_meta;
    end
  end

  logic              sdi_s, sclk_rise, sclk_fall, frame_start, frame_end;
  logic              seg_done, aligned;
  logic [SEG_W-1:0]  seg_word, addr_word, data_word;
  logic              mode, hdr_ok;
  logic [PCNT_W-1:0] pay_cnt;

  dsd_pin_sampler u_pins (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .sclk_pin    (spi_sclk),
    .cs_n_pin    (spi_cs_n),
    .sdi_pin     (spi_mosi),
    .sdi_s       (sdi_s),
    .sclk_rise   (sclk_rise),
    .sclk_fall   (sclk_fall),
    .frame_start (frame_start),
    .frame_end   (frame_end)
  );

  dsd_shift_path #(.SEG_W(SEG_W), .FAULT_W(FAULT_W)) u_shift (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .frame_start (frame_start),
    .frame_end   (frame_end),
    .sclk_rise   (sclk_rise),
    .sclk_fall   (sclk_fall),
    .sdi_s       (sdi_s),
    .fault       (fault_in),
    .seg_done    (seg_done),
    .seg_word    (seg_word),
    .aligned     (aligned),
    .sdo         (spi_miso)
  );

  dsd_seg_track #(.SEG_W(SEG_W), .LEN_W(LEN_W), .PCNT_W(PCNT_W)) u_track (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .frame_start (frame_start),
    .daisy_en    (daisy_en),
    .seg_done    (seg_done),
    .seg_word    (seg_word),
    .mode        (mode),
    .hdr_ok      (hdr_ok),
    .pay_cnt     (pay_cnt),
    .chain_len   (chain_len),
    .addr_word   (addr_word),
    .data_word   (data_word)
  );

  dsd_cmd_issue #(.SEG_W(SEG_W), .LEN_W(LEN_W), .PCNT_W(PCNT_W)) u_issue (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .frame_end   (frame_end),
    .aligned     (aligned),
    .mode        (mode),
    .hdr_ok      (hdr_ok),
    .pay_cnt     (pay_cnt),
    .chain_len   (chain_len),
    .addr_word   (addr_word),
    .data_word   (data_word),
    .wr_stb      (wr_stb),
    .rd_req      (rd_req),
    .frame_err   (frame_err),
    .seq_err     (seq_err),
    .cmd_addr    (cmd_addr),
    .cmd_data    (cmd_data)
  );

endmodule

// File: rtl/dsd_checker.sv
module dsd_checker #(
  parameter int LEN_W = 13
) (
  input logic             clk,
  input logic             rst_n,
  input logic             spi_cs_n,
  input logic             spi_miso,
  input logic             wr_stb,
  input logic             rd_req,
  input logic             frame_err,
  input logic             seq_err,
  input logic [LEN_W-1:0] chain_len
);

  assert_one_outcome_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({wr_stb, rd_req, frame_err, seq_err}));

  assert_wr_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |=> !wr_stb);

  assert_rd_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |=> !rd_req);

  assert_cmd_after_cs_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb || rd_req) |-> (spi_cs_n && $past(spi_cs_n)));

  assert_frame_err_after_cs_R6: assert property (@(posedge clk) disable iff (!rst_n)
    frame_err |-> (spi_cs_n && $past(spi_cs_n)));

  assert_idle_miso_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (spi_cs_n && $past(spi_cs_n) && $past(spi_cs_n, 2) && $past(spi_cs_n, 3))
      |-> !spi_miso);

  assert_len_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (spi_cs_n && $past(spi_cs_n) && $past(spi_cs_n, 2) && $past(spi_cs_n, 3))
      |-> $stable(chain_len));

endmodule

bind daisy_seg_decoder dsd_checker #(.LEN_W(LEN_W)) u_dsd_checker (
  .clk       (clk),
  .rst_n     (rst_n),
  .spi_cs_n  (spi_cs_n),
  .spi_miso  (spi_miso),
  .wr_stb    (wr_stb),
  .rd_req    (rd_req),
  .frame_err (frame_err),
  .seq_err   (seq_err),
  .chain_len (chain_len)
);

// File: tb/daisy_seg_decoder_test.sv
`timescale 1ns/1ps
module daisy_seg_decoder_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        daisy_en = 1'b0;
  logic [5:0]  fault_in = '0;
  logic        spi_sclk = 1'b0;
  logic        spi_cs_n = 1'b1;
  logic        spi_mosi = 1'b0;
  logic        spi_miso, wr_stb, rd_req, frame_err, seq_err;
  logic [14:0] cmd_addr;
  logic [15:0] cmd_data;
  logic [12:0] chain_len;

  always #4 clk = ~clk;

  daisy_seg_decoder uut (
    .clk(clk), .rst_n(rst_n), .daisy_en(daisy_en), .fault_in(fault_in),
    .spi_sclk(spi_sclk), .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi),
    .spi_miso(spi_miso), .wr_stb(wr_stb), .rd_req(rd_req),
    .cmd_addr(cmd_addr), .cmd_data(cmd_data), .chain_len(chain_len),
    .frame_err(frame_err), .seq_err(seq_err)
  );

  int n_checks = 0;
  int n_errors = 0;
  bit done = 0;
  bit run_mon = 0;
  bit window = 0;

  // Reference model state
  bit          tx_q[$];
  int          exp_kind;  // 0 write, 1 read, 2 frame_err, 3 seq_err
  logic [15:0] exp_addr, exp_data;
  logic [12:0] exp_len = '0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic add_seg(input logic [15:0] w);
    for (int i = 15; i >= 0; i--) tx_q.push_back(w[i]);
  endtask

  task automatic model_frame(input bit daisy);
    logic [15:0] segs[$];
    int nseg, rem, idx, p;
    bit hdr;
    nseg = tx_q.size() / 16;
    rem  = tx_q.size() % 16;
    for (int s = 0; s < nseg; s++) begin
      logic [15:0] w;
      for (int b = 0; b < 16; b++) w[15-b] = tx_q[s*16+b];
      segs.push_back(w);
    end
    idx = 1;
    hdr = 0;
    if (daisy) begin
      while (idx < nseg && segs[idx][15:14] == 2'b11) idx++;
      if (idx < nseg && segs[idx][15:14] == 2'b01) begin
        hdr = 1;
        exp_len = segs[idx][12:0];
        idx++;
      end
    end
    p = (nseg > idx) ? nseg - idx : 0;
    if (rem != 0) exp_kind = 2;
    else if (daisy ? (hdr && p >= 2 && p % 2 == 0 && p <= 2 * int'(exp_len)) : (p == 2)) begin
      exp_addr = segs[nseg-2];
      exp_data = segs[nseg-1];
      exp_kind = exp_addr[15] ? 1 : 0;
    end else exp_kind = 3;
  endtask

  // Outside the end-of-frame window no outcome pulse may appear (R10).
  always @(negedge clk) begin
    if (run_mon && !window && !done)
      chk("R10 idle outcome", {28'd0, wr_stb, rd_req, frame_err, seq_err}, 32'd0);
  end

  task automatic run_frame(input bit daisy, input logic [5:0] flt, input bit join_end,
                           input string req);
    logic [15:0] stat;
    logic exp_bit;
    int n;
    model_frame(daisy);
    stat = {2'b11, flt, 8'h00};
    n = tx_q.size();
    @(negedge clk);
    daisy_en = daisy;
    fault_in = flt;
    spi_sclk = 1'b0;
    spi_cs_n = 1'b0;
    repeat (4) @(negedge clk);
    for (int i = 0; i < n; i++) begin
      spi_mosi = tx_q[i];
      repeat (4) @(negedge clk);
      exp_bit = (i < 16) ? stat[15-i] : tx_q[i-16];
      chk((i < 16) ? "R2 status bit" : "R3 forwarded bit", {31'd0, spi_miso}, {31'd0, exp_bit});
      if (join_end && i == n - 1) begin
        spi_sclk = 1'b1;
        spi_cs_n = 1'b1;
      end else begin
        spi_sclk = 1'b1;
        repeat (2) @(negedge clk);
        chk("R1 output steady over rising edge", {31'd0, spi_miso}, {31'd0, exp_bit});
        repeat (2) @(negedge clk);
        spi_sclk = 1'b0;
      end
    end
    if (!join_end) begin
      repeat (4) @(negedge clk);
      spi_cs_n = 1'b1;
    end
    window = 1;
    repeat (3) @(negedge clk);
    chk({req, " outcome wr/rd/fe/se"}, {28'd0, wr_stb, rd_req, frame_err, seq_err},
        {28'd0, exp_kind == 0, exp_kind == 1, exp_kind == 2, exp_kind == 3});
    if (exp_kind < 2) begin
      chk("R5 cmd_addr", {17'd0, cmd_addr}, {17'd0, exp_addr[14:0]});
      chk("R5 cmd_data", {16'd0, cmd_data}, {16'd0, exp_data});
    end
    chk("R4 chain_len", {19'd0, chain_len}, {19'd0, exp_len});
    @(negedge clk);
    window = 0;
    spi_sclk = 1'b0;
    repeat (4) @(negedge clk);
    chk("R2 idle output low", {31'd0, spi_miso}, 32'd0);
    tx_q.delete();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R9: reset state
    chk("R9 reset outcomes", {28'd0, wr_stb, rd_req, frame_err, seq_err}, 32'd0);
    chk("R9 reset cmd_addr", {17'd0, cmd_addr}, 32'd0);
    chk("R9 reset cmd_data", {16'd0, cmd_data}, 32'd0);
    chk("R9 reset chain_len", {19'd0, chain_len}, 32'd0);
    chk("R9 reset miso", {31'd0, spi_miso}, 32'd0);
    run_mon = 1;

    // R5/R4: chained write, two devices
    add_seg(16'hC000); add_seg(16'h4002);
    add_seg(16'h8005); add_seg(16'h0000); add_seg(16'h0123); add_seg(16'hBEEF);
    run_frame(1, 6'h2A, 0, "R5 chained write");

    // R4: upstream status skipped, chained read
    add_seg(16'hC400); add_seg(16'hFF00); add_seg(16'h4003);
    add_seg(16'h0001); add_seg(16'h1111); add_seg(16'h0002); add_seg(16'h2222);
    add_seg(16'h8456); add_seg(16'h0000);
    run_frame(1, 6'h15, 0, "R4 skip status then read");

    // R8: single mode write
    add_seg(16'h1234); add_seg(16'h0042); add_seg(16'hA5A5);
    run_frame(0, 6'h00, 0, "R8 single write");

    // R5: single mode read, last clock edge with chip-select rise
    add_seg(16'h0000); add_seg(16'hFFFE); add_seg(16'h5555);
    run_frame(0, 6'h3F, 1, "R5 joined end read");

    // R6: 40 bits, header still captured
    add_seg(16'h0000); add_seg(16'h4005);
    for (int i = 0; i < 8; i++) tx_q.push_back(i[0]);
    run_frame(1, 6'h01, 0, "R6 misaligned end");

    // R7: too many pairs for chain length 1
    add_seg(16'h0000); add_seg(16'h4001);
    add_seg(16'h0011); add_seg(16'h1111); add_seg(16'h0022); add_seg(16'h2222);
    run_frame(1, 6'h20, 0, "R7 pairs exceed chain");

    // R7: no header
    add_seg(16'h0000); add_seg(16'h0010); add_seg(16'h2222);
    run_frame(1, 6'h10, 0, "R7 missing header");

    // R7: odd payload count
    add_seg(16'h0000); add_seg(16'h4004);
    add_seg(16'h0011); add_seg(16'h1111); add_seg(16'h0022);
    run_frame(1, 6'h08, 0, "R7 odd payload");

    // R8: single mode with three payload segments
    add_seg(16'h0000); add_seg(16'h0001); add_seg(16'h0002); add_seg(16'h0003);
    run_frame(0, 6'h04, 0, "R8 single wrong count");

    // R8: header-looking address in single mode is an address
    add_seg(16'hC000); add_seg(16'h4001); add_seg(16'h0F0F);
    run_frame(0, 6'h02, 0, "R8 header id as address");

    // R4: reserved bit 13 set, maximum length, joined end write
    add_seg(16'h0000); add_seg(16'h7FFF); add_seg(16'h7ABC); add_seg(16'h1357);
    run_frame(1, 6'h33, 1, "R4 max length joined write");

    done = 1;
    $display("  Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

endmodule